// File: doc/BRIEF.md
# Serial Controller Queue and Watermark Interrupt Unit

This block holds the transmit and receive queues of a serial controller and presents them to software through a small 32-bit register window. Software writes frames into the transmit queue through a data register and drains received frames through another. The full and empty flags are not in a separate status register. They are reported in the top bit of the two data registers, so a single access both moves a frame and reports the queue state.

Toward the shift engine the block offers a valid/ready stream out of the transmit queue and accepts frames into the receive queue under a ready signal. Software sets an occupancy threshold for each queue. A pending flag is raised while the transmit queue has drained below its threshold, or while the receive queue has filled past its own. Each flag has an enable. The single interrupt line is level sensitive and stays high as long as any enabled flag is pending.

Register word offsets: 0x00 transmit data, 0x04 receive data, 0x08 transmit threshold, 0x0C receive threshold, 0x10 interrupt enable, 0x14 interrupt pending. Bit 0 of the enable and pending registers is the transmit flag and bit 1 is the receive flag. Read data is combinational on the address. Side effects take place at the clock edge on which the strobe is sampled.

Top module: `sqw_queues`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) both queues are empty, the transmit threshold reads 1, the receive threshold reads 0, the enable register reads 0 and irq is low.
- R2: A write to offset 0x00 enqueues bus_wdata[7:0] when the transmit queue is not full. tx_valid is high whenever the queue holds a frame, and tx_data shows the oldest frame. A frame leaves the queue on each edge where tx_valid and tx_ready are both high, so frames come out in write order.
- R3: A read of offset 0x00 returns bit 31 set exactly when the transmit queue holds DEPTH frames, and all other bits zero. A write to offset 0x00 while the queue is full is dropped, and no later frame carries its value.
- R4: A read of offset 0x04 on a non-empty receive queue returns the oldest frame in bits 7:0 with bit 31 clear. Each edge with bus_rd high at that offset removes exactly one frame.
- R5: A read of offset 0x04 on an empty receive queue returns 0x8000_0000 and removes nothing.
- R6: rx_ready is low exactly when the receive queue holds DEPTH frames. A frame is stored on each edge with rx_valid and rx_ready both high.
- R7: Pending bit 0 (offset 0x14) is 1 exactly while transmit occupancy is strictly less than the transmit threshold.
- R8: Pending bit 1 is 1 exactly while receive occupancy is strictly greater than the receive threshold.
- R9: Pending bits follow occupancy alone. Writes to offset 0x14 and to offset 0x04 change no register and no queue.
- R10: irq is high exactly when some pending bit is 1 and its enable bit at offset 0x10 is 1, in the same cycle.
- R11: The thresholds store bus_wdata[CNT_W-1:0] and the enables store bus_wdata[1:0]. Each reads back zero-extended. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one edge per access |
| bus_rd | input | 1 | Read strobe, one edge per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tx_valid | output | 1 | Transmit queue holds a frame |
| tx_ready | input | 1 | Shift engine takes the head frame |
| tx_data | output | FRAME_W | Oldest transmit frame |
| rx_valid | input | 1 | Shift engine offers a received frame |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | FRAME_W | Received frame |
| irq | output | 1 | Level interrupt |

## Verification
The bench fills the transmit queue to exactly DEPTH and writes one more frame. A design that accepted the extra frame would corrupt the oldest entry or send a ninth frame. It holds bus_rd for several edges against an empty receive queue, which would underflow the pointers in a design that pops without checking for empty. It also reads full queues while the engine pushes or pops on the same edge, which would exercise a wrong occupancy count. Thresholds are swept across 0, the queue depth and values above it. A design that used non-strict comparisons, or that latched the pending flags instead of deriving them from occupancy, would miss or hold the interrupt at those edges.

// File: rtl/sqw_pkg.sv
// Shared constants for the serial queue block.
// Assumes a 32-bit register bus with word offsets decoded from address bits 4:2.
package sqw_pkg;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 5;
    localparam int FLAG_BIT = 31;
    localparam int TXWM_BIT = 0;
    localparam int RXWM_BIT = 1;
    localparam int IRQ_W    = 2;

    typedef enum logic [2:0] {
        SEL_TXQ    = 3'd0,
        SEL_RXQ    = 3'd1,
        SEL_TXMARK = 3'd2,
        SEL_RXMARK = 3'd3,
        SEL_IE     = 3'd4,
        SEL_IP     = 3'd5
    } sqw_sel_e;
endpackage

// File: rtl/sqw_fifo.sv
// Synchronous circular queue with an occupancy count.
// Push is ignored when full and pop is ignored when empty, both judged on the
// state before the edge. Assumes DEPTH >= 2. Any depth is supported; a power
// of two uses natural pointer wrap.
module sqw_fifo #(
    parameter int DEPTH   = 8,
    parameter int WIDTH   = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_nxt, rd_nxt;
    logic             do_push, do_pop;

    // Status from the occupancy count.
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Pointer advance: plain wrap for powers of two, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_any
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sqw_regs.sv
// Register window: decodes the bus, holds the thresholds and enables, and
// builds read data. Read data is combinational on the address. The receive
// pop is issued once per edge with bus_rd at the receive data offset.
module sqw_regs
    import sqw_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic               tx_full,
    input  logic               rx_empty,
    input  logic [FRAME_W-1:0] rx_head,
    input  logic [IRQ_W-1:0]   ip,
    output logic               tx_push,
    output logic [FRAME_W-1:0] tx_wdata,
    output logic               rx_pop,
    output logic [CNT_W-1:0]   tx_mark,
    output logic [CNT_W-1:0]   rx_mark,
    output logic [IRQ_W-1:0]   ie
);
    logic [2:0] sel;

    // Word select from the byte address.
    assign sel      = bus_addr[4:2];
    assign tx_push  = bus_wr && (sel == SEL_TXQ);
    assign tx_wdata = bus_wdata[FRAME_W-1:0];
    assign rx_pop   = bus_rd && (sel == SEL_RXQ);

    // Threshold and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mark <= CNT_W'(1);
            rx_mark <= '0;
            ie      <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_TXMARK: tx_mark <= bus_wdata[CNT_W-1:0];
                SEL_RXMARK: rx_mark <= bus_wdata[CNT_W-1:0];
                SEL_IE:     ie      <= bus_wdata[IRQ_W-1:0];
                default:    ;
            endcase
        end
    end

    // Read multiplexer with the queue flags in the top bit.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_TXQ:    bus_rdata[FLAG_BIT] = tx_full;
            SEL_RXQ: begin
                bus_rdata[FLAG_BIT] = rx_empty;
                if (!rx_empty) bus_rdata[FRAME_W-1:0] = rx_head;
            end
            SEL_TXMARK: bus_rdata[CNT_W-1:0] = tx_mark;
            SEL_RXMARK: bus_rdata[CNT_W-1:0] = rx_mark;
            SEL_IE:     bus_rdata[IRQ_W-1:0] = ie;
            SEL_IP:     bus_rdata[IRQ_W-1:0] = ip;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sqw_irq.sv
// Watermark logic: pending flags are derived from occupancy every cycle and
// are never stored, so they clear as soon as the condition goes false.
module sqw_irq
    import sqw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_mark,
    input  logic [CNT_W-1:0] rx_mark,
    input  logic [IRQ_W-1:0] ie,
    output logic [IRQ_W-1:0] ip,
    output logic             irq
);
    // Strict comparisons against the two thresholds.
    always_comb begin
        ip           = '0;
        ip[TXWM_BIT] = (tx_count < tx_mark);
        ip[RXWM_BIT] = (rx_count > rx_mark);
    end

    // Enabled flags merged into one level output.
    assign irq = |(ip & ie);
endmodule

// File: rtl/sqw_queues.sv
// Top of the queue block: two queues, the register window and the watermark
// logic. Assumes single-cycle bus strobes and a shift engine that follows
// the valid/ready rules on both streams.
module sqw_queues
    import sqw_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [FRAME_W-1:0] tx_data,
    input  logic               rx_valid,
    output logic               rx_ready,
    input  logic [FRAME_W-1:0] rx_data,
    output logic               irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]   tx_count, rx_count, tx_mark_q, rx_mark_q;
    logic [IRQ_W-1:0]   ie_q, ip_w;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic               tx_push, rx_pop;
    logic [FRAME_W-1:0] tx_wdata, rx_head;

    // Stream handshakes toward the shift engine.
    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    sqw_fifo #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_wdata),
        .pop(tx_ready), .head(tx_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    sqw_fifo #(.DEPTH(DEPTH), .WIDTH(FRAME_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_valid), .push_data(rx_data),
        .pop(rx_pop), .head(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    sqw_regs #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_full(tx_full), .rx_empty(rx_empty), .rx_head(rx_head),
        .ip(ip_w), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .rx_pop(rx_pop), .tx_mark(tx_mark_q), .rx_mark(rx_mark_q), .ie(ie_q)
    );

    sqw_irq #(.CNT_W(CNT_W)) u_irq (
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_mark(tx_mark_q), .rx_mark(rx_mark_q),
        .ie(ie_q), .ip(ip_w), .irq(irq)
    );
endmodule

// File: rtl/sqw_queues_chk.sv
// Property checker for the queue block, bound into every instance of the top.
module sqw_queues_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             irq,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_mark,
    input logic [CNT_W-1:0] rx_mark,
    input logic [1:0]       ie
);
    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_mark == CNT_W'(1) && rx_mark == '0 && ie == '0 && !irq));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CNT_W'(DEPTH) && rx_count <= CNT_W'(DEPTH));

    assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == CNT_W'(DEPTH) && bus_wr && bus_addr[4:2] == 3'd0 && !tx_ready)
        |=> tx_count == CNT_W'(DEPTH));

    assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[4:2] == 3'd1 && rx_count != '0 && !(rx_valid && rx_ready))
        |=> rx_count == $past(rx_count) - 1'b1);

    assert_rx_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count == CNT_W'(DEPTH) |-> !rx_ready);

    assert_tx_mark_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b01 && !tx_valid && tx_mark != '0) |-> irq);

    assert_rx_mark_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == 2'b10 && rx_count == '0) |-> !irq);

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ie == 2'b00 |-> !irq);
endmodule

bind sqw_queues sqw_queues_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_mark(tx_mark_q), .rx_mark(rx_mark_q), .ie(ie_q)
);

// File: tb/sqw_queues_tb_top.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a queue model kept in the bench.
module sqw_queues_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int FW         = 8;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          tx_valid, tx_ready = 1'b0;
    logic [FW-1:0] tx_data;
    logic          rx_valid = 1'b0, rx_ready;
    logic [FW-1:0] rx_data = '0;
    logic          irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    logic [FW-1:0] m_tx[$];
    logic [FW-1:0] m_rx[$];
    logic [CW-1:0] m_txm, m_rxm;
    logic [1:0]    m_ie;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sqw_queues #(.DEPTH(DEPTH), .FRAME_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_ip();
        exp_ip = {(m_rx.size() > int'(m_rxm)), (m_tx.size() < int'(m_txm))};
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        logic [31:0] r = '0;
        case (a)
            5'h00: r[31] = (m_tx.size() == DEPTH);
            5'h04: r = (m_rx.size() == 0) ? 32'h8000_0000 : {24'h0, m_rx[0]};
            5'h08: r = 32'(m_txm);
            5'h0C: r = 32'(m_rxm);
            5'h10: r = 32'(m_ie);
            5'h14: r = 32'(exp_ip());
            default: r = '0;
        endcase
        return r;
    endfunction

    // One clock cycle: drive after the falling edge, check, update the model.
    task automatic cycle(input logic [4:0] a, input logic wr, input logic rd,
                         input logic [31:0] wd, input logic txr,
                         input logic rxv, input logic [FW-1:0] rxd);
        int ptx, prx;
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        tx_ready = txr; rx_valid = rxv; rx_data = rxd;
        #1;
        ptx = m_tx.size();
        prx = m_rx.size();
        if (rd) begin
            case (a)
                5'h00: check("R3 tx full flag", bus_rdata, exp_read(a));
                5'h04: check((prx == 0) ? "R5 empty read" : "R4 rx read", bus_rdata, exp_read(a));
                5'h14: check("R7/R8 pending", bus_rdata, exp_read(a));
                default: check("R11 readback", bus_rdata, exp_read(a));
            endcase
        end
        check("R10 irq", 32'(irq), 32'(|(exp_ip() & m_ie)));
        check("R2 tx_valid", 32'(tx_valid), 32'(ptx != 0));
        if (ptx != 0) check("R2 tx order", 32'(tx_data), 32'(m_tx[0]));
        check("R6 rx_ready", 32'(rx_ready), 32'(prx != DEPTH));
        if (txr && ptx > 0) void'(m_tx.pop_front());
        if (wr && a == 5'h00 && ptx < DEPTH) m_tx.push_back(wd[FW-1:0]);
        if (rxv && prx < DEPTH) m_rx.push_back(rxd);
        if (rd && a == 5'h04 && prx > 0) void'(m_rx.pop_front());
        if (wr && a == 5'h08) m_txm = wd[CW-1:0];
        if (wr && a == 5'h0C) m_rxm = wd[CW-1:0];
        if (wr && a == 5'h10) m_ie  = wd[1:0];
    endtask

    task automatic rd_reg(input logic [4:0] a);
        cycle(a, 1'b0, 1'b1, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        cycle(a, 1'b1, 1'b0, d, 1'b0, 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        m_txm = CW'(1); m_rxm = '0; m_ie = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of every register.
        rd_reg(5'h08); rd_reg(5'h0C); rd_reg(5'h10); rd_reg(5'h14);
        rd_reg(5'h00);
        rd_reg(5'h04);
        check("R1 irq after reset", 32'(irq), 32'd0);

        // R3: fill the transmit queue, then overfill.
        wr_reg(5'h10, 32'h3);
        for (int i = 0; i < DEPTH; i++) wr_reg(5'h00, 32'hA0 + i);
        rd_reg(5'h00);
        wr_reg(5'h00, 32'h5A);
        rd_reg(5'h14);
        // R2: drain in order, the dropped frame never appears.
        for (int i = 0; i < DEPTH + 2; i++) cycle(5'h14, 1'b0, 1'b1, '0, 1'b1, 1'b0, '0);
        check("R3 dropped frame absent", 32'(tx_valid), 32'd0);

        // R6: fill the receive queue past full.
        for (int i = 0; i < DEPTH + 2; i++) cycle(5'h14, 1'b0, 1'b1, '0, 1'b0, 1'b1, FW'(8'h30 + i));
        // R9: writes to pending and receive data change nothing.
        wr_reg(5'h14, 32'h0);
        wr_reg(5'h04, 32'hFF);
        rd_reg(5'h14);
        // R4/R5: drain, then hold the read strobe on an empty queue.
        for (int i = 0; i < DEPTH + 3; i++) rd_reg(5'h04);
        // R4: pop while the engine pushes on the same edge.
        cycle(5'h04, 1'b0, 1'b0, '0, 1'b0, 1'b1, 8'h77);
        cycle(5'h04, 1'b0, 1'b1, '0, 1'b0, 1'b1, 8'h78);
        rd_reg(5'h04);
        rd_reg(5'h04);

        // R7/R8/R11: threshold sweeps including 0, DEPTH and above.
        for (int m = 0; m <= DEPTH + 2; m++) begin
            wr_reg(5'h08, 32'(m) | 32'hFFFF_FFF0);
            wr_reg(5'h0C, 32'(m));
            rd_reg(5'h08); rd_reg(5'h0C); rd_reg(5'h14);
        end
        rd_reg(5'h18); rd_reg(5'h1C);

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            logic [4:0]  a;
            logic [31:0] d;
            int          op;
            op = int'($urandom % 16);
            a  = 5'(($urandom % 8) * 4);
            d  = $urandom;
            if (op < 3)       cycle(5'h00, 1'b1, 1'b0, d, $urandom % 3 == 0, $urandom % 2 == 0, FW'($urandom));
            else if (op < 7)  cycle(5'h04, 1'b0, 1'b1, d, $urandom % 2 == 0, $urandom % 3 == 0, FW'($urandom));
            else if (op < 8)  cycle(a, 1'b1, 1'b0, (a == 5'h08 || a == 5'h0C) ? (d % (DEPTH + 2)) : d,
                                    $urandom % 2 == 0, $urandom % 2 == 0, FW'($urandom));
            else              cycle(a, 1'b0, 1'b1, d, $urandom % 2 == 0, $urandom % 2 == 0, FW'($urandom));
        end
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule